// File: doc/BRIEF.md
# Three-Slot Fresh-Data Mailbox

This block carries single data items from a producer to a consumer with neither side ever waiting for the other's progress. It uses three storage slots and three slot indices, each holding 0, 1 or 2:
- `nxt_q` is the slot the next write will fill.
- `last_q` is the slot holding the most recently published item.
- `read_q` is the slot the consumer currently owns.

A consumer always obtains the newest complete item. A producer never writes into a slot that holds the published item or the item being read. Because of this, no item is ever seen half-written.

A write runs three internal steps in order: store the input into the next slot, publish that slot as the latest, then choose a fresh next slot. A read runs two: claim the latest slot, then present its contents. The choose step and the claim step share a one-cycle arbiter that favours the writer, so the slot indices never change from both sides in the same cycle.

Each side talks through a four-phase request/acknowledge handshake. The block reports two events:
- When a published item is replaced before any read claimed it, the write that replaced it raises `wr_skip`.
- When a read claims an item that an earlier read already claimed, that read raises `rd_stale`.

Top module: `fresh3_mailbox`

## Requirements
- R1: While reset is held and after it is released, `wr_ack`, `rd_ack`, `wr_skip`, `rd_stale` are 0 and `rd_data` is 0; the slot indices start as next=0, last=1, read=1 with every slot zero, so a first read returns 0 with `rd_stale`=1.
- R2: A write starts at the first rising edge that sees `wr_req`=1 while the writer is idle; `wr_ack` goes to 1 after the fourth rising edge counted from that edge (inclusive), stays 1 while `wr_req` stays 1, and drops at the edge after `wr_req` falls. `wr_data` must be held while `wr_req` is 1.
- R3: A read starts at the first rising edge that sees `rd_req`=1 while the reader is idle; without contention `rd_ack` goes to 1 after the third edge, and `rd_data` holds its value while `rd_ack` is 1.
- R4: A read returns the item of the last write whose publish step came before the read's claim step.
- R5: The writer never stores into the slot that is published as latest or the slot being read, so every read returns exactly a value that was written, never a mix.
- R6: When the writer's choose step and the reader's claim step fall in the same cycle, the writer is granted; the claim is granted one cycle later, so the read takes four edges and returns the item just published.
- R7: `wr_skip`, valid while `wr_ack` is 1, is 1 when the write's publish step replaced an item that no read had claimed; it is cleared when the next write starts.
- R8: `rd_stale`, valid while `rd_ack` is 1, is 1 when the claimed item had already been claimed by an earlier read (or is the reset item); it is cleared when the next read starts.
- R9: The choose step sets the next slot to the one value differing from both last and read; when last equals read it picks the lowest-numbered slot other than last.
- R10: A claim on the same edge as a publish takes the previously published item, and that item does not count as skipped (`wr_skip`=0 for that write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, held until `wr_ack` |
| wr_data | input | DATA_W | Item to write, held while `wr_req` is 1 |
| wr_ack | output | 1 | Write complete |
| wr_skip | output | 1 | Previous unread item was replaced by this write |
| rd_req | input | 1 | Read request, held until `rd_ack` |
| rd_data | output | DATA_W | Item read |
| rd_ack | output | 1 | Read complete |
| rd_stale | output | 1 | This read repeated an already-claimed item |

## Verification
The bound checker watches the slot-index invariants on every cycle:
- the arbiter never grants both sides at once;
- a store never targets the latest or the claimed slot;
- the choose step always lands on the third distinct slot;
- the read index moves only on a granted claim;
- both acknowledges stay up, and read data holds, until their requests fall.

Freshness, the skip and stale flag values, and the exact latency penalty of a collision depend on the order of operations. Only the bench's scenarios can show these. The scenarios are a fixed write/read sequence plus directed overlaps in which the reader's claim lands on the writer's publish edge or inside its choose cycle.

// File: rtl/fresh3_mailbox.sv
module fresh3_mailbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  output logic              wr_skip,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  output logic              rd_stale
);
  localparam int NSLOT = 3;

  typedef enum logic [2:0] {W_IDLE, W_STORE, W_PUB, W_CHOOSE, W_ACK} wr_state_t;
  typedef enum logic [1:0] {R_IDLE, R_CLAIM, R_OUT, R_ACK} rd_state_t;

  wr_state_t ws;
  rd_state_t rs;
  logic [1:0] nxt_q, last_q, read_q;
  logic [DATA_W-1:0] slot_q [NSLOT];
  logic fresh_q;
  logic grant_w, grant_r, pub, store;

  function automatic logic [1:0] pick_free(input logic [1:0] a, input logic [1:0] b);
    if (a == b) return (a == 2'd0) ? 2'd1 : 2'd0;
    return 2'd3 - a - b;
  endfunction

  assign store   = (ws == W_STORE);
  assign pub     = (ws == W_PUB);
  assign grant_w = (ws == W_CHOOSE);
  assign grant_r = (rs == R_CLAIM) && !grant_w;
  assign wr_ack  = (ws == W_ACK);
  assign rd_ack  = (rs == R_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws      <= W_IDLE;
      nxt_q   <= 2'd0;
      last_q  <= 2'd1;
      wr_skip <= 1'b0;
    end else begin
      case (ws)
        W_IDLE:   if (wr_req) begin ws <= W_STORE; wr_skip <= 1'b0; end
        W_STORE:  ws <= W_PUB;
        W_PUB:    begin
                    last_q  <= nxt_q;
                    wr_skip <= fresh_q && !grant_r;
                    ws      <= W_CHOOSE;
                  end
        W_CHOOSE: begin
                    nxt_q <= pick_free(last_q, read_q);
                    ws    <= W_ACK;
                  end
        W_ACK:    if (!wr_req) ws <= W_IDLE;
        default:  ws <= W_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (store) begin
      slot_q[nxt_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       fresh_q <= 1'b0;
    else if (pub)     fresh_q <= 1'b1;
    else if (grant_r) fresh_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs       <= R_IDLE;
      read_q   <= 2'd1;
      rd_data  <= '0;
      rd_stale <= 1'b0;
    end else begin
      case (rs)
        R_IDLE:  if (rd_req) begin rs <= R_CLAIM; rd_stale <= 1'b0; end
        R_CLAIM: if (grant_r) begin
                   read_q   <= last_q;
                   rd_stale <= !fresh_q;
                   rs       <= R_OUT;
                 end
        R_OUT:   begin rd_data <= slot_q[read_q]; rs <= R_ACK; end
        R_ACK:   if (!rd_req) rs <= R_IDLE;
        default: rs <= R_IDLE;
      endcase
    end
  end
endmodule

module fresh3_mailbox_check #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              wr_ack,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              store,
  input logic              grant_w,
  input logic              grant_r,
  input logic [1:0]        nxt_q,
  input logic [1:0]        last_q,
  input logic [1:0]        read_q
);
  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_w && grant_r));
  assert_store_free_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> (nxt_q != last_q) && (nxt_q != read_q));
  assert_choose_distinct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w |=> (nxt_q != last_q) && (nxt_q != read_q) && (nxt_q < 2'd3));
  assert_read_moves_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_r |=> $stable(read_q));
  assert_wr_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_req) |=> wr_ack);
  assert_rd_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && rd_req) |=> (rd_ack && $stable(rd_data)));
endmodule

bind fresh3_mailbox fresh3_mailbox_check #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ack(wr_ack),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
  .store(store), .grant_w(grant_w), .grant_r(grant_r),
  .nxt_q(nxt_q), .last_q(last_q), .read_q(read_q)
);

// File: tb/fresh3_mailbox_test.sv
module fresh3_mailbox_test;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0, wr_req = 0, rd_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ack, wr_skip, rd_ack, rd_stale;
  logic [DW-1:0] rd_data;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  fresh3_mailbox #(.DATA_W(DW)) uut (.*);

  // {is_read, flag, value}: writes give data and expected wr_skip,
  // reads give expected data and expected rd_stale
  localparam logic [9:0] VEC [12] = '{
    {1'b1,1'b1,8'h00}, {1'b0,1'b0,8'h11}, {1'b1,1'b0,8'h11}, {1'b1,1'b1,8'h11},
    {1'b0,1'b0,8'h22}, {1'b0,1'b1,8'h33}, {1'b1,1'b0,8'h33}, {1'b0,1'b0,8'h44},
    {1'b0,1'b1,8'h55}, {1'b0,1'b1,8'h66}, {1'b1,1'b0,8'h66}, {1'b1,1'b1,8'h66}};

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] d, output int lat, output int sk);
    @(negedge clk); wr_data = d; wr_req = 1; lat = 0;
    do begin @(negedge clk); lat++; end while (!wr_ack && lat < 20);
    sk = wr_skip; wr_req = 0;
    @(negedge clk);
  endtask

  task automatic do_read(output int d, output int lat, output int st);
    @(negedge clk); rd_req = 1; lat = 0;
    do begin @(negedge clk); lat++; end while (!rd_ack && lat < 20);
    d = rd_data; st = rd_stale;
    @(negedge clk);
    chk("R3 rd_data held while ack", rd_data, d);
    rd_req = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wl, ws, rl, rv, rst;
    repeat (3) @(negedge clk);
    chk("R1 wr_ack in reset", wr_ack, 0);
    chk("R1 rd_ack in reset", rd_ack, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 wr_skip after reset", wr_skip, 0);
    chk("R1 rd_stale after reset", rd_stale, 0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][9]) begin
        do_read(rv, rl, rst);
        chk("R4 R5 read value", rv, int'(VEC[i][7:0]));
        chk("R8 stale flag", rst, int'(VEC[i][8]));
        chk("R3 read latency", rl, 3);
      end else begin
        do_write(VEC[i][7:0], wl, ws);
        chk("R7 skip flag", ws, int'(VEC[i][8]));
        chk("R2 write latency", wl, 4);
      end
    end

    // R10: claim on the publish edge takes the previous item (66, already read)
    fork
      do_write(8'h77, wl, ws);
      begin @(negedge clk); do_read(rv, rl, rst); end
    join
    chk("R10 claim on publish edge value", rv, 8'h66);
    chk("R10 stale of repeated item", rst, 1);
    chk("R10 no skip", ws, 0);
    do_read(rv, rl, rst);
    chk("R4 newest after overlap", rv, 8'h77);
    chk("R8 fresh read", rst, 0);

    // R10: unread item claimed on the publish edge is not a skip
    do_write(8'h99, wl, ws);
    fork
      do_write(8'hAA, wl, ws);
      begin @(negedge clk); do_read(rv, rl, rst); end
    join
    chk("R10 claimed unread item", rv, 8'h99);
    chk("R10 skip suppressed", ws, 0);
    chk("R8 not stale", rst, 0);

    // R6: claim inside choose cycle waits one cycle, sees new item
    fork
      do_write(8'hBB, wl, ws);
      begin repeat (2) @(negedge clk); do_read(rv, rl, rst); end
    join
    chk("R6 collided read latency", rl, 4);
    chk("R6 collided read value", rv, 8'hBB);
    chk("R6 write latency unchanged", wl, 4);
    chk("R7 AA was unread, skip", ws, 1);

    // R9 R5: a stream of writes between reads never corrupts the claimed item
    for (int k = 0; k < 6; k++) begin
      do_write(8'hC0 + 8'(k), wl, ws);
      if (k % 2 == 1) begin
        do_read(rv, rl, rst);
        chk("R9 R5 slot rotation value", rv, 8'hC0 + k);
      end
    end

    // R2: ack stays while request held
    @(negedge clk); wr_data = 8'h5A; wr_req = 1;
    repeat (6) @(negedge clk);
    chk("R2 ack held", wr_ack, 1);
    wr_req = 0; @(negedge clk);
    chk("R2 ack drops", wr_ack, 0);

    // R1: reset again, first read returns reset item as stale
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    do_read(rv, rl, rst);
    chk("R1 reset item value", rv, 0);
    chk("R1 reset item stale", rst, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule